// File: doc/BRIEF.md
# Host Access Port with Cycle-Stealing Memory Arbiter

This block lets a host processor read and write the shared display refresh memory while the refresh sequencer keeps running. The host reaches the block through I/O commands. Each command carries a 6-bit device code and three pulse bits that act in a fixed time order. The block holds a host address register and a host data buffer. It decodes the commands and decides, one memory cycle at a time, whether the next cycle goes to the host or to the refresh sequencer.

In normal operation a host access only takes a slot that the sequencer leaves free, for example while it waits on a busy display generator. The host can switch on a priority override so that its requests win over refresh fetches instead. A memory cycle that has already started always runs to completion. A busy status line tells the host whether its last requested operation is still outstanding. An optional auto-index mode steps the host address after each completed host cycle. The memory array and the sequencer's word decode are outside the block. They connect through a start/done memory port and a request/grant refresh port.

Top module: `hp_port`

## Requirements
- R1: Once `mem_start` has pulsed, no further `mem_start` pulse occurs until `mem_done` has been seen, and at most one requester is granted per slot.
- R2: While the override flag is set, a pending host request is granted before an asserted `rf_req` at the next free slot.
- R3: While the override flag is clear, an asserted `rf_req` is granted before a pending host request. The host request waits for a slot in which `rf_req` is low.
- R4: A host request stays latched until it is granted. `host_busy` is high from the cycle after the request command until the cycle after that request's `mem_done`.
- R5: A refresh grant drives `mem_addr` from `rf_addr` with `mem_we` low. A host grant drives the host address register and host buffer. Refresh cycles never alter the host buffer.
- R6: With auto-index on, the host address register increments by one, modulo 2^AW, after each completed host read or write.
- R7: A host-address load or clear in the same cycle as a host completion takes precedence, and no increment occurs.
- R8: The pulse bits act in the order io_ops[0] (first pulse), then io_ops[1] (second), then io_ops[2] (third) within one command. For example, on device octal 72 with all three bits set, the buffer is cleared, then loaded from `io_wdata`, and the loaded value is written.
- R9: Device octal 72: first pulse clears the buffer, second loads it from `io_wdata`, third requests a write of the buffer to memory at the host address. Device octal 73: first pulse clears the host address, second loads it from `io_wdata[AW-1:0]`, third requests a read from memory at the host address into the buffer.
- R10: Device octal 75: first pulse sets `io_skip` for one cycle if a host operation is outstanding. The third pulse copies the buffer to `io_rdata`, which holds its value until the next such copy or an initialize.
- R11: Device octal 71: first pulse initializes the block. It clears the host address, the buffer, `io_rdata`, auto-index, the override and any outstanding host request, and pulses `seq_init`. The second pulse sets the override and the third clears it. Device octal 70, first pulse, pulses `seq_start` for one cycle.
- R12: Only one host request is outstanding at a time. A read or write request that arrives while one is pending or in flight is dropped, and `host_busy` stays high.
- R13: Device octal 74: first pulse turns auto-index on and second pulse turns it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | One-cycle command strobe |
| io_dev | input | 6 | Device code of the command |
| io_ops | input | 3 | Pulse bits: [0] first, [1] second, [2] third |
| io_wdata | input | DW | Host output data |
| io_rdata | output | DW | Host input bus, buffer copy |
| io_skip | output | 1 | One-cycle skip response |
| host_busy | output | 1 | Host operation outstanding |
| seq_start | output | 1 | Start pulse to refresh sequencer |
| seq_init | output | 1 | Initialize pulse to refresh sequencer |
| rf_req | input | 1 | Refresh fetch request, held until granted |
| rf_addr | input | AW | Refresh fetch address |
| rf_grant | output | 1 | Refresh fetch granted, coincides with mem_start |
| mem_start | output | 1 | Memory cycle start pulse |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_done |
| mem_done | input | 1 | Memory cycle complete |

## Verification
The bench builds the block with AW = 8 and DW = 12. The narrower address, distinct from the data width, makes the modulo wrap of the auto-indexed address (255 to 0) reachable in a few cycles. It also exercises the truncation of `io_wdata` on an address load. A 256-word memory model with a three-cycle latency lets randomized refresh traffic and host accesses interleave, while the bench keeps a full shadow copy. A mode that holds `rf_req` permanently high starves the host, which brings the override, the single-outstanding rule and the skip response within reach.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int PULSE_A = 0;
  localparam int PULSE_B = 1;
  localparam int PULSE_C = 2;
  localparam int NUM_DEV = 6;

  typedef struct packed {
    logic buf_clr;
    logic buf_ld;
    logic wr_req;
    logic adr_clr;
    logic adr_ld;
    logic rd_req;
    logic idx_on;
    logic idx_off;
    logic skip_q;
    logic buf_out;
    logic init;
    logic ovr_on;
    logic ovr_off;
    logic seq_go;
  } hp_cmd_t;
endpackage

// File: rtl/hp_cmd_dec.sv
module hp_cmd_dec
  import hp_pkg::*;
#(
  parameter logic [5:0] DEV_BASE = 6'o70
) (
  input  logic       io_valid,
  input  logic [5:0] io_dev,
  input  logic [2:0] io_ops,
  output hp_cmd_t    cmd
);
  logic [5:0]         rel;
  logic [NUM_DEV-1:0] sel;

  assign rel = io_dev - DEV_BASE;

  genvar g;
  generate
    for (g = 0; g < NUM_DEV; g++) begin : g_sel
      assign sel[g] = io_valid && (rel == 6'(g));
    end
  endgenerate

  always_comb begin
    cmd         = '0;
    cmd.seq_go  = sel[0] & io_ops[PULSE_A];
    cmd.init    = sel[1] & io_ops[PULSE_A];
    cmd.ovr_on  = sel[1] & io_ops[PULSE_B];
    cmd.ovr_off = sel[1] & io_ops[PULSE_C];
    cmd.buf_clr = sel[2] & io_ops[PULSE_A];
    cmd.buf_ld  = sel[2] & io_ops[PULSE_B];
    cmd.wr_req  = sel[2] & io_ops[PULSE_C];
    cmd.adr_clr = sel[3] & io_ops[PULSE_A];
    cmd.adr_ld  = sel[3] & io_ops[PULSE_B];
    cmd.rd_req  = sel[3] & io_ops[PULSE_C];
    cmd.idx_on  = sel[4] & io_ops[PULSE_A];
    cmd.idx_off = sel[4] & io_ops[PULSE_B];
    cmd.skip_q  = sel[5] & io_ops[PULSE_A];
    cmd.buf_out = sel[5] & io_ops[PULSE_C];
  end
endmodule

// File: rtl/hp_arb.sv
module hp_arb (
  input  logic clk,
  input  logic rst,
  input  logic host_req,
  input  logic ovr,
  input  logic rf_req,
  input  logic mem_done,
  output logic grant_host,
  output logic grant_rf,
  output logic busy
);
  logic free;

  assign free = !busy;

  always_comb begin
    grant_host = 1'b0;
    grant_rf   = 1'b0;
    if (free) begin
      if (ovr && host_req)      grant_host = 1'b1;
      else if (rf_req)          grant_rf   = 1'b1;
      else if (host_req)        grant_host = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          busy <= 1'b0;
    else if (grant_host || grant_rf)  busy <= 1'b1;
    else if (mem_done)                busy <= 1'b0;
  end

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant_host, grant_rf}));

  assert_ovr_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (ovr && host_req && !busy) |-> grant_host);

  assert_refresh_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (!ovr && rf_req && !busy) |-> grant_rf);
endmodule

// File: rtl/hp_hostregs.sv
module hp_hostregs
  import hp_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  hp_cmd_t       cmd,
  input  logic [DW-1:0] io_wdata,
  input  logic          grant_host,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] iob,
  output logic          host_req,
  output logic          host_we,
  output logic          ovr,
  output logic [DW-1:0] io_rdata,
  output logic          io_skip,
  output logic          host_busy,
  output logic          seq_start,
  output logic          seq_init
);
  logic          act, idx;
  logic [AW-1:0] n_mar;
  logic [DW-1:0] n_iob;
  logic          n_req, n_act, n_we, n_idx, n_ovr, fin, busy_now;

  assign fin      = act && mem_done;
  assign busy_now = host_req || act;

  always_comb begin
    n_mar = mar;
    n_iob = iob;
    n_req = host_req;
    n_act = act;
    n_we  = host_we;
    n_idx = idx;
    n_ovr = ovr;
    if (fin) begin
      n_act = 1'b0;
      if (!host_we) n_iob = mem_rdata;
      if (idx)      n_mar = mar + 1'b1;
    end
    if (grant_host) begin
      n_req = 1'b0;
      n_act = 1'b1;
    end
    if (cmd.init) begin
      n_mar = '0;
      n_iob = '0;
      n_req = 1'b0;
      n_act = 1'b0;
      n_idx = 1'b0;
      n_ovr = 1'b0;
    end
    if (cmd.adr_clr) n_mar = '0;
    if (cmd.adr_ld)  n_mar = io_wdata[AW-1:0];
    if (cmd.buf_clr) n_iob = '0;
    if (cmd.buf_ld)  n_iob = io_wdata;
    if (cmd.idx_on)  n_idx = 1'b1;
    if (cmd.idx_off) n_idx = 1'b0;
    if (cmd.ovr_on)  n_ovr = 1'b1;
    if (cmd.ovr_off) n_ovr = 1'b0;
    if ((cmd.rd_req || cmd.wr_req) && !(n_req || n_act)) begin
      n_req = 1'b1;
      n_we  = cmd.wr_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar       <= '0;
      iob       <= '0;
      host_req  <= 1'b0;
      act       <= 1'b0;
      host_we   <= 1'b0;
      idx       <= 1'b0;
      ovr       <= 1'b0;
      io_rdata  <= '0;
      io_skip   <= 1'b0;
      host_busy <= 1'b0;
      seq_start <= 1'b0;
      seq_init  <= 1'b0;
    end else begin
      mar       <= n_mar;
      iob       <= n_iob;
      host_req  <= n_req;
      act       <= n_act;
      host_we   <= n_we;
      idx       <= n_idx;
      ovr       <= n_ovr;
      host_busy <= n_req || n_act;
      io_skip   <= cmd.skip_q && busy_now;
      seq_start <= cmd.seq_go;
      seq_init  <= cmd.init;
      if (cmd.init)         io_rdata <= '0;
      else if (cmd.buf_out) io_rdata <= iob;
    end
  end

  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (host_req && !grant_host && !cmd.init) |=> host_req);

  assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
    (fin && idx && !cmd.adr_ld && !cmd.adr_clr && !cmd.init)
      |=> (mar == AW'($past(mar) + 1'b1)));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd.adr_ld && !cmd.init) |=> (mar == $past(io_wdata[AW-1:0])));

  assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (rst)
    (busy_now && !fin && !cmd.init && (cmd.rd_req || cmd.wr_req))
      |=> ($stable(host_we) && host_busy));
endmodule

// File: rtl/hp_port.sv
module hp_port
  import hp_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          DW       = 12,
  parameter logic [5:0]  DEV_BASE = 6'o70
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_valid,
  input  logic [5:0]    io_dev,
  input  logic [2:0]    io_ops,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_skip,
  output logic          host_busy,
  output logic          seq_start,
  output logic          seq_init,
  input  logic          rf_req,
  input  logic [AW-1:0] rf_addr,
  output logic          rf_grant,
  output logic          mem_start,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done
);
  hp_cmd_t       cmd;
  logic [AW-1:0] mar;
  logic [DW-1:0] iob;
  logic          host_req, host_we, ovr;
  logic          grant_host, grant_rf, arb_busy;

  hp_cmd_dec #(.DEV_BASE(DEV_BASE)) u_dec (
    .io_valid (io_valid),
    .io_dev   (io_dev),
    .io_ops   (io_ops),
    .cmd      (cmd)
  );

  hp_hostregs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .io_wdata   (io_wdata),
    .grant_host (grant_host),
    .mem_done   (mem_done),
    .mem_rdata  (mem_rdata),
    .mar        (mar),
    .iob        (iob),
    .host_req   (host_req),
    .host_we    (host_we),
    .ovr        (ovr),
    .io_rdata   (io_rdata),
    .io_skip    (io_skip),
    .host_busy  (host_busy),
    .seq_start  (seq_start),
    .seq_init   (seq_init)
  );

  hp_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .ovr        (ovr),
    .rf_req     (rf_req),
    .mem_done   (mem_done),
    .grant_host (grant_host),
    .grant_rf   (grant_rf),
    .busy       (arb_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_start <= 1'b0;
      rf_grant  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_start <= grant_host || grant_rf;
      rf_grant  <= grant_rf;
      if (grant_host) begin
        mem_we    <= host_we;
        mem_addr  <= mar;
        mem_wdata <= iob;
      end else if (grant_rf) begin
        mem_we   <= 1'b0;
        mem_addr <= rf_addr;
      end
    end
  end

  assert_no_preempt_R1: assert property (@(posedge clk) disable iff (rst)
    (arb_busy && !mem_done) |=> !mem_start);

  assert_refresh_path_R5: assert property (@(posedge clk) disable iff (rst)
    rf_grant |-> (!mem_we && mem_addr == $past(rf_addr)));
endmodule

// File: tb/hp_port_bench.sv
module hp_port_bench;
  localparam int AW  = 8;
  localparam int DW  = 12;
  localparam int LAT = 3;
  localparam int NW  = 1 << AW;
  localparam logic [5:0] D70 = 6'o70, D71 = 6'o71, D72 = 6'o72,
                         D73 = 6'o73, D74 = 6'o74, D75 = 6'o75;

  logic clk = 1'b0, rst = 1'b1;
  logic io_valid = 1'b0;
  logic [5:0] io_dev = '0;
  logic [2:0] io_ops = '0;
  logic [DW-1:0] io_wdata = '0;
  logic [DW-1:0] io_rdata, mem_wdata, mem_rdata;
  logic io_skip, host_busy, seq_start, seq_init, rf_grant, mem_start, mem_we, mem_done;
  logic rf_req = 1'b0;
  logic [AW-1:0] rf_addr = '0, mem_addr, lat_addr = '0;
  logic auto_done = 1'b0, man_done = 1'b0, man_mode = 1'b0;
  int rf_mode = 0, cnt = 0;
  int vectors = 0, miscompares = 0, host_starts = 0, host_wr = 0;
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] ref_mem [NW];

  always #10 clk = ~clk;

  hp_port #(.AW(AW), .DW(DW)) u_hp_port (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_dev(io_dev), .io_ops(io_ops),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_skip(io_skip), .host_busy(host_busy),
    .seq_start(seq_start), .seq_init(seq_init), .rf_req(rf_req), .rf_addr(rf_addr),
    .rf_grant(rf_grant), .mem_start(mem_start), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  assign mem_done  = man_mode ? man_done : auto_done;
  assign mem_rdata = mem[lat_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    return ref_mem[a];
  endfunction

  function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] a);
    return AW'(a + 1);
  endfunction

  // memory and refresh sequencer models, acting away from the active edge
  always @(negedge clk) begin
    auto_done = 1'b0;
    if (mem_start) begin
      if (cnt != 0 && !man_mode) chk("R1 start during cycle", 1, 0);
      cnt = LAT;
      lat_addr = mem_addr;
      if (rf_grant) begin
        chk("R5 refresh addr", {24'd0, mem_addr}, {24'd0, rf_addr});
        chk("R5 refresh no write", {31'd0, mem_we}, 0);
      end else begin
        host_starts++;
        if (mem_we) host_wr++;
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
    end else if (cnt != 0) begin
      cnt--;
      if (cnt == 0) auto_done = 1'b1;
    end
    if (rf_grant) begin
      rf_req = (rf_mode == 2);
      rf_addr = AW'($urandom);
    end else if (rf_mode == 0) rf_req = 1'b0;
    else if (rf_mode == 2) rf_req = 1'b1;
    else if (!rf_req && ($urandom % 3) == 0) begin
      rf_req = 1'b1;
      rf_addr = AW'($urandom);
    end
  end

  task automatic cmd(input logic [5:0] d, input logic [2:0] ops, input logic [DW-1:0] w);
    @(negedge clk);
    io_valid = 1'b1; io_dev = d; io_ops = ops; io_wdata = w;
    @(negedge clk);
    io_valid = 1'b0; io_ops = '0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (host_busy && n < 2000) begin @(negedge clk); n++; end
    chk(req, {31'd0, host_busy}, 0);
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    cmd(D73, 3'b111, DW'(a));
    wait_idle("R4 read completes");
    cmd(D75, 3'b100, '0);
    d = io_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int hs, hw;
    void'($urandom(32'd4242));
    for (int i = 0; i < NW; i++) begin ref_mem[i] = DW'($urandom); mem[i] = ref_mem[i]; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R4 reset busy", {31'd0, host_busy}, 0);
    chk("R10 reset rdata", {20'd0, io_rdata}, 0);
    chk("R1 reset start", {31'd0, mem_start}, 0);
    chk("R10 reset skip", {31'd0, io_skip}, 0);

    // R11: start pulse
    cmd(D70, 3'b001, '0);
    chk("R11 seq_start", {31'd0, seq_start}, 1);
    @(negedge clk);
    chk("R11 seq_start one cycle", {31'd0, seq_start}, 0);

    // R8: clear then load within one command, readout
    cmd(D72, 3'b011, 12'h5A3);
    cmd(D75, 3'b100, '0);
    chk("R8 clear-then-load", {20'd0, io_rdata}, 32'h5A3);

    // random traffic with refresh stealing slots
    rf_mode = 1;
    for (int it = 0; it < 160; it++) begin
      logic [AW-1:0] a = AW'($urandom);
      if ($urandom % 2) begin
        logic [DW-1:0] w = DW'($urandom);
        cmd(D73, 3'b010, DW'(a));
        cmd(D72, 3'b111, w);           // R8, R9 write
        wait_idle("R4 write completes");
        ref_mem[a] = w;
      end else begin
        host_read(a, d);
        chk("R9 read data", {20'd0, d}, {20'd0, exp_read(a)});
      end
    end
    rf_mode = 0;
    repeat (LAT + 3) @(negedge clk);

    // R13, R6: auto-index on, consecutive reads, wrap at 2^AW
    cmd(D74, 3'b001, '0);
    cmd(D73, 3'b010, 12'd10);
    cmd(D73, 3'b100, '0); wait_idle("R6 idle");
    cmd(D73, 3'b100, '0); wait_idle("R6 idle");
    cmd(D75, 3'b100, '0);
    chk("R6 second read at next addr", {20'd0, io_rdata}, {20'd0, exp_read(exp_next(8'd10))});
    cmd(D73, 3'b010, 12'hFFF);         // truncated to 255
    cmd(D73, 3'b100, '0); wait_idle("R6 idle");
    cmd(D73, 3'b100, '0); wait_idle("R6 idle");
    cmd(D75, 3'b100, '0);
    chk("R6 wrap to zero", {20'd0, io_rdata}, {20'd0, exp_read(exp_next(8'd255))});
    cmd(D74, 3'b010, '0);              // R13 off
    cmd(D73, 3'b010, 12'd20);
    cmd(D73, 3'b100, '0); wait_idle("R13 idle");
    cmd(D73, 3'b100, '0); wait_idle("R13 idle");
    cmd(D75, 3'b100, '0);
    chk("R13 auto-index off", {20'd0, io_rdata}, {20'd0, exp_read(8'd20)});

    // R7: address load in the completion cycle beats the increment
    cmd(D74, 3'b001, '0);
    cmd(D73, 3'b010, 12'd30);
    man_mode = 1'b1;
    cmd(D73, 3'b100, '0);
    repeat (LAT + 2) @(negedge clk);
    man_done = 1'b1; io_valid = 1'b1; io_dev = D73; io_ops = 3'b010; io_wdata = 12'd40;
    @(negedge clk);
    man_done = 1'b0; io_valid = 1'b0; io_ops = '0; man_mode = 1'b0;
    chk("R4 busy drops after done", {31'd0, host_busy}, 0);
    cmd(D74, 3'b010, '0);
    cmd(D73, 3'b100, '0); wait_idle("R7 idle");
    cmd(D75, 3'b100, '0);
    chk("R7 load beats increment", {20'd0, io_rdata}, {20'd0, exp_read(8'd40)});

    // R3, R4, R10, R12, R2: starve host with constant refresh
    rf_mode = 2;
    repeat (4) @(negedge clk);
    hs = host_starts; hw = host_wr;
    cmd(D73, 3'b110, 12'd50);
    repeat (25) @(negedge clk);
    chk("R3 host waits behind refresh", host_starts - hs, 0);
    chk("R4 busy while pending", {31'd0, host_busy}, 1);
    cmd(D75, 3'b001, '0);
    chk("R10 skip while busy", {31'd0, io_skip}, 1);
    cmd(D72, 3'b100, '0);              // second request, dropped
    chk("R12 busy stays", {31'd0, host_busy}, 1);
    cmd(D71, 3'b010, '0);              // override on
    wait_idle("R2 override grants host");
    repeat (LAT + 3) @(negedge clk);
    chk("R12 one host cycle only", host_starts - hs, 1);
    chk("R12 dropped write not done", host_wr - hw, 0);
    cmd(D75, 3'b100, '0);
    chk("R2 read data under override", {20'd0, io_rdata}, {20'd0, exp_read(8'd50)});
    cmd(D71, 3'b100, '0);              // override off
    cmd(D75, 3'b001, '0);
    chk("R10 no skip when idle", {31'd0, io_skip}, 0);

    // R11: initialize drops pending request and clears registers
    hs = host_starts;
    cmd(D73, 3'b100, '0);
    repeat (5) @(negedge clk);
    cmd(D71, 3'b001, '0);
    chk("R11 seq_init", {31'd0, seq_init}, 1);
    chk("R11 busy cleared", {31'd0, host_busy}, 0);
    chk("R11 rdata cleared", {20'd0, io_rdata}, 0);
    rf_mode = 0;
    repeat (LAT + 4) @(negedge clk);
    chk("R11 dropped request never runs", host_starts - hs, 0);
    cmd(D75, 3'b100, '0);
    chk("R11 buffer cleared", {20'd0, io_rdata}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule